// File: doc/BRIEF.md
# Read/Write Slot Arbiter

This block sits in front of a synchronous SRAM that has an independent read port and write port sharing one command slot per clock. On every rising clock edge it samples an active-low select for each port and decides whether a read, a write, or nothing begins in the following cycle. At most one transaction begins per cycle. The winner is chosen from what began in the previous cycle: after a read the write port wins, after a write the read port wins, and after an idle cycle the read port wins. A read therefore never follows a read, and a write never follows a write.

Each start raises a one-cycle strobe for its port, latches that port's address and marks the port as occupied for the length of its burst. A burst of `BURST_WORDS` words occupies its port for `BURST_WORDS/2` cycles (two cycles by default), starting with the strobe cycle. A burst always runs to completion, even if its select is released, and the block reports itself idle only once no burst is in flight. A request that loses arbitration is dropped; it has to be presented again at a later edge.

Top module: `rw_slot_arbiter`

## Requirements
- R1: Read strobe and write strobe are never both high in the same cycle.
- R2: Selects are active low and are sampled only on the rising clock edge. A start strobe is high during the cycle that follows the edge at which it won. With both selects high, no strobe is raised.
- R3: When both selects are low at an edge, no start happened in the preceding cycle, and neither port is occupied, the read starts.
- R4: When both selects are low at an edge that follows a read start, the write starts. A read strobe is never high in two consecutive cycles.
- R5: When both selects are low at an edge that follows a write start and the read port is free, the read starts. A write strobe is never high in two consecutive cycles.
- R6: When both selects are held low starting from idle, the strobes go read, write, read, write, read on consecutive cycles.
- R7: A losing request is not queued. If its select is high at the next edge, no start follows for that port.
- R8: A start sets its port's burst flag high for BEATS = BURST_WORDS/2 cycles, starting with the strobe cycle. A new start on the same port is granted only at an edge where at most one busy cycle remains.
- R9: A burst runs to completion regardless of later select values. The idle output is high exactly when neither burst flag is high.
- R10: The start address output of each port takes the address input present at the winning edge and holds it until that port's next start.
- R11: After reset, both strobes and both burst flags are low, idle is high, and the last-start history is "none".
- R12: When only one select is held low, that port starts on every cycle it is allowed to: every second cycle by default. The other port's state does not change this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all decisions on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read-port select, active low |
| wr_sel_n | input | 1 | Write-port select, active low |
| rd_addr_i | input | ADDR_W | Read address offered with the read select |
| wr_addr_i | input | ADDR_W | Write address offered with the write select |
| rd_start_o | output | 1 | One-cycle strobe: a read begins |
| wr_start_o | output | 1 | One-cycle strobe: a write begins |
| rd_addr_o | output | ADDR_W | Address latched at the last read start |
| wr_addr_o | output | ADDR_W | Address latched at the last write start |
| rd_burst_o | output | 1 | Read burst in flight |
| wr_burst_o | output | 1 | Write burst in flight |
| idle_o | output | 1 | No burst in flight on either port |

## Verification
The bench holds both selects low from idle and checks the exact read-first alternation. A design that used a fixed priority would emit a run of reads. A design that started with the write would be one slot out of phase for the whole run. A losing read is released right after the edge at which it lost, so a design that queued requests shows up as a phantom read strobe. A read is started and then both selects are dropped, which exposes a design whose burst flag or idle output follows the select instead of the burst length. A long random run is then compared every cycle against a behavioural model, and it flags any back-to-back read or write starts.

// File: rtl/rw_slot_arbiter.sv
module rw_slot_arbiter #(
  parameter int ADDR_W      = 20,
  parameter int BURST_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              rd_start_o,
  output logic              wr_start_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_burst_o,
  output logic              wr_burst_o,
  output logic              idle_o
);

  localparam int BEATS = (BURST_WORDS + 1) / 2;
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;

  logic [1:0]       last_op;
  logic [CNT_W-1:0] rd_left, wr_left;
  logic             rd_free, wr_free, grant_rd, grant_wr;

  assign rd_free  = rd_left <= CNT_W'(1);
  assign wr_free  = wr_left <= CNT_W'(1);
  assign grant_rd = !rd_sel_n && rd_free && (last_op != OP_RD);
  assign grant_wr = !wr_sel_n && wr_free && (last_op != OP_WR) && !grant_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op   <= OP_NONE;
      rd_left   <= '0;
      wr_left   <= '0;
      rd_addr_o <= '0;
      wr_addr_o <= '0;
    end else begin
      last_op <= grant_rd ? OP_RD : (grant_wr ? OP_WR : OP_NONE);
      if (grant_rd) begin
        rd_left   <= CNT_W'(BEATS);
        rd_addr_o <= rd_addr_i;
      end else if (rd_left != '0) begin
        rd_left <= rd_left - CNT_W'(1);
      end
      if (grant_wr) begin
        wr_left   <= CNT_W'(BEATS);
        wr_addr_o <= wr_addr_i;
      end else if (wr_left != '0) begin
        wr_left <= wr_left - CNT_W'(1);
      end
    end
  end

  assign rd_start_o = (last_op == OP_RD);
  assign wr_start_o = (last_op == OP_WR);
  assign rd_burst_o = (rd_left != '0);
  assign wr_burst_o = (wr_left != '0);
  assign idle_o     = !rd_burst_o && !wr_burst_o;

endmodule

// File: rtl/rw_slot_arbiter_chk.sv
module rw_slot_arbiter_chk #(
  parameter int ADDR_W      = 20,
  parameter int BURST_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_sel_n,
  input logic              wr_sel_n,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              rd_start_o,
  input logic              wr_start_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rd_burst_o,
  input logic              wr_burst_o,
  input logic              idle_o
);
  localparam bit MULTI = ((BURST_WORDS + 1) / 2) > 1;

  p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start_o && wr_start_o));
  p_rd_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_n && wr_sel_n) |=> (!rd_start_o && !wr_start_o));
  p_rd_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && !wr_sel_n && !rd_start_o && !wr_start_o && idle_o) |=> rd_start_o);
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel_n && rd_start_o && !wr_burst_o) |=> wr_start_o);
  p_no_rd_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_o |=> !rd_start_o);
  p_rd_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && wr_start_o && !rd_burst_o) |=> rd_start_o);
  p_no_wr_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |=> !wr_start_o);
  p_rd_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_o |-> (rd_burst_o && !idle_o));
  p_wr_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> (wr_burst_o && !idle_o));
  p_rd_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (MULTI && rd_start_o) |=> rd_burst_o);
  p_wr_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (MULTI && wr_start_o) |=> wr_burst_o);
  p_rd_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_o |=> (!rd_start_o && $stable(rd_addr_o)));
  p_wr_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n || rd_sel_n) && wr_start_o |=> (!wr_start_o && $stable(wr_addr_o)));
endmodule

bind rw_slot_arbiter rw_slot_arbiter_chk #(
  .ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
  .rd_addr_i(rd_addr_i), .wr_addr_i(wr_addr_i),
  .rd_start_o(rd_start_o), .wr_start_o(wr_start_o),
  .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o),
  .rd_burst_o(rd_burst_o), .wr_burst_o(wr_burst_o), .idle_o(idle_o)
);

// File: tb/rw_slot_arbiter_tb_top.sv
module rw_slot_arbiter_tb_top;
  localparam int AW = 20;
  localparam int BW = 4;
  localparam int NBEAT = (BW + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] rd_addr_i = '0, wr_addr_i = '0;
  logic rd_start_o, wr_start_o, rd_burst_o, wr_burst_o, idle_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;

  int errors = 0, checks = 0;
  int m_last = 0, m_rl = 0, m_wl = 0;
  longint m_ra = 0, m_wa = 0;
  bit prev_rd = 0, prev_wr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rw_slot_arbiter #(.ADDR_W(AW), .BURST_WORDS(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_addr_i(rd_addr_i), .wr_addr_i(wr_addr_i),
    .rd_start_o(rd_start_o), .wr_start_o(wr_start_o),
    .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o),
    .rd_burst_o(rd_burst_o), .wr_burst_o(wr_burst_o), .idle_o(idle_o));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(input bit rs, input bit ws, input string tag);
    bit rgo, wgo;
    logic [AW-1:0] ra, wa;
    @(negedge clk);
    check("R1", longint'(rd_start_o & wr_start_o), 0);
    check(tag, longint'(rd_start_o), longint'(m_last == 1));
    check(tag, longint'(wr_start_o), longint'(m_last == 2));
    check("R4", longint'(prev_rd & rd_start_o), 0);
    check("R5", longint'(prev_wr & wr_start_o), 0);
    check("R8", longint'(rd_burst_o), longint'(m_rl != 0));
    check("R8", longint'(wr_burst_o), longint'(m_wl != 0));
    check("R9", longint'(idle_o), longint'(m_rl == 0 && m_wl == 0));
    check("R10", longint'(rd_addr_o), m_ra);
    check("R10", longint'(wr_addr_o), m_wa);
    prev_rd = rd_start_o;
    prev_wr = wr_start_o;
    ra = AW'($urandom);
    wa = AW'($urandom);
    rgo = !rs && m_rl <= 1 && m_last != 1;
    wgo = !ws && m_wl <= 1 && m_last != 2 && !rgo;
    if (rgo) begin m_rl = NBEAT; m_ra = longint'(ra); end
    else if (m_rl > 0) m_rl--;
    if (wgo) begin m_wl = NBEAT; m_wa = longint'(wa); end
    else if (m_wl > 0) m_wl--;
    m_last = rgo ? 1 : (wgo ? 2 : 0);
    rd_sel_n = rs; wr_sel_n = ws; rd_addr_i = ra; wr_addr_i = wa;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11", longint'(rd_start_o), 0);
    check("R11", longint'(wr_start_o), 0);
    check("R11", longint'(rd_burst_o | wr_burst_o), 0);
    check("R11", longint'(idle_o), 1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1, 1, "R2");

    // R6 alternation from idle, read first (R3)
    for (int i = 0; i < 6; i++) begin
      step(0, 0, "R3");
      if (i >= 1) begin
        check("R6", longint'(rd_start_o), longint'(i % 2 == 1));
        check("R6", longint'(wr_start_o), longint'(i % 2 == 0));
      end
    end
    for (int i = 0; i < 3; i++) step(1, 1, "R2");

    // R12 single port held
    for (int i = 0; i < 8; i++) step(0, 1, "R12");
    for (int i = 0; i < 3; i++) step(1, 1, "R2");
    for (int i = 0; i < 8; i++) step(1, 0, "R12");
    for (int i = 0; i < 3; i++) step(1, 1, "R2");

    // R7 losing read is dropped
    step(0, 1, "R7");
    step(0, 0, "R7");
    check("R7", longint'(rd_start_o), 1);
    step(1, 1, "R7");
    check("R4", longint'(wr_start_o), 1);
    check("R7", longint'(rd_start_o), 0);
    step(1, 1, "R7");
    check("R7", longint'(rd_start_o), 0);
    for (int i = 0; i < 3; i++) step(1, 1, "R2");

    // R9 burst completes after deselect
    step(0, 1, "R9");
    step(1, 1, "R9");
    check("R9", longint'(rd_burst_o), 1);
    step(1, 1, "R9");
    check("R9", longint'(rd_burst_o), 1);
    check("R9", longint'(idle_o), 0);
    step(1, 1, "R9");
    check("R9", longint'(idle_o), 1);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) step(1'($urandom), 1'($urandom), "R5");
    step(1, 1, "R2");
    done = 1;
    summary();
  end
endmodule